// File: doc/BRIEF.md
# Six-Stage Pipeline Flow Sequencer

This block tracks and steers instructions through an in-order pipeline of six stages: fetch, decode with register read, operand address calculation, operand fetch or memory access, execute, and write back. Each stage after fetch holds one slot. A slot carries a valid bit, the instruction's index (used as its tag), and four descriptor flags: conditional branch, branch outcome, branch target index, and whether the instruction touches memory in operand fetch or in write back. At most six instructions are in flight, one per stage. No data is computed and no register file is modelled. Only the flow of instructions is controlled.

The surrounding logic reads `fetch_idx` and returns, in the same cycle, the descriptor of the instruction at that index. One memory port is shared by three users, in fixed priority order: write back, then operand fetch, then fetch. A user that loses arbitration waits in place. A taken conditional branch is resolved in execute. The four younger instructions are then squashed, and fetch moves to the branch target. An interrupt drops every instruction that is not already in write back, and fetch moves to a fixed handler index.

Each cycle the controller makes exactly one decision, taken from an enumerated set, in priority order:
- `ACT_IRQ`: an interrupt is pending.
- `ACT_SQUASH`: a taken branch is in execute.
- `ACT_OF_WAIT`: operand fetch lost the memory port to write back.
- `ACT_FI_WAIT`: fetch lost the memory port to operand fetch or write back.
- `ACT_FLOW`: fetch won the port and everything advances.

Every cycle is classified afresh; no decision carries over to the next cycle.

Top module: `pipe6_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fetch_idx` equals the reset index (default 0), `done_valid` is 0, and no slot is valid. The first completion can appear no earlier than cycle 5.
- R2: When no memory access and no branch is present, an instruction fetched in cycle t completes in cycle t+5. `done_valid` is 1 and `done_tag` equals its fetch index. Completions come one per cycle, in fetch order.
- R3: `mem_grant` uses this encoding: 1 = fetch, 2 = operand fetch, 3 = write back. Priority is write back first, then operand fetch, then fetch. Fetch requests the port in every cycle.
- R4: If operand fetch and write back both request the port, write back is served. The operand-fetch instruction and every instruction behind it hold their stages, a bubble enters execute, and `fetch_idx` does not change.
- R5: If only fetch loses the port, a bubble enters decode, the younger stages advance, and `fetch_idx` does not change.
- R6: An instruction without a memory access makes no request for the port in operand fetch or in write back. While only such instructions flow, `mem_grant` stays 1.
- R7: A conditional branch whose outcome is not taken causes no squash. Sequential fetch and completion continue with no gap.
- R8: A taken branch is resolved when it is in execute. The four younger instructions are discarded. `fetch_idx` equals the target in the next cycle. No completion occurs in the four cycles after the branch completes.
- R9: A taken branch in execute overrides an operand-fetch stall in the same cycle. Fetch is still redirected to the target in the next cycle.
- R10: An interrupt in cycle t lets the instruction in write back complete in cycle t. All other in-flight instructions are discarded, and `fetch_idx` equals the handler index (default 0xF0) in cycle t+1.
- R11: An interrupt in the same cycle as a taken branch in execute wins. Fetch goes to the handler index, and the branch does not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request, sampled each cycle |
| in_br | input | 1 | Instruction at `fetch_idx` is a conditional branch |
| in_taken | input | 1 | Outcome of that branch: 1 = taken |
| in_tgt | input | IDX_W | Branch target index |
| in_opnd_mem | input | 1 | Instruction needs the memory port in operand fetch |
| in_wb_mem | input | 1 | Instruction needs the memory port in write back |
| fetch_idx | output | IDX_W | Index being fetched this cycle |
| mem_grant | output | 2 | User of the memory port this cycle (1, 2 or 3) |
| done_valid | output | 1 | An instruction completes in write back this cycle |
| done_tag | output | IDX_W | Index of the completing instruction |

## Verification
The bench drives six kinds of instruction streams and checks each against its own expectations:
- A plain sequential stream fixes the baseline latency and throughput.
- A stream with a write-back store and an operand-fetch load that meet in one cycle separates an operand-fetch stall from a fetch-only stall. It does this through the grant sequence and the completion cycles.
- A not-taken branch and a taken branch to the same target separate squashing from plain flow.
- A taken branch placed in a cycle with a memory conflict shows which of the two wins.
- An interrupt on a sequential stream shows the drain and the handler restart.
- An interrupt in the cycle a branch resolves shows the priority between those two events.

// File: rtl/pipe6_pkg.sv
package pipe6_pkg;

    localparam int NSTG   = 6;
    localparam int OF_STG = 3;
    localparam int EX_STG = 4;
    localparam int WB_STG = 5;

    typedef enum logic [1:0] {
        GNT_NONE  = 2'd0,
        GNT_FETCH = 2'd1,
        GNT_OPND  = 2'd2,
        GNT_WBACK = 2'd3
    } gnt_e;

    typedef enum logic [2:0] {
        ACT_FLOW,
        ACT_FI_WAIT,
        ACT_OF_WAIT,
        ACT_SQUASH,
        ACT_IRQ
    } act_e;

endpackage

// File: rtl/pipe6_port_arb.sv
module pipe6_port_arb
    import pipe6_pkg::*;
(
    input  logic wb_req,
    input  logic of_req,
    input  logic fi_req,
    output gnt_e gnt
);

    always_comb begin
        if (wb_req) begin
            gnt = GNT_WBACK;
        end else if (of_req) begin
            gnt = GNT_OPND;
        end else if (fi_req) begin
            gnt = GNT_FETCH;
        end else begin
            gnt = GNT_NONE;
        end
    end

endmodule

// File: rtl/pipe6_ctl.sv
module pipe6_ctl
    import pipe6_pkg::*;
(
    input  logic             irq,
    input  logic             ex_taken,
    input  logic             of_req,
    input  gnt_e             gnt,
    output act_e             act,
    output logic [NSTG-1:1]  kill,
    output logic [NSTG-1:1]  hold,
    output logic             fetch_take
);

    // decision for this cycle, highest priority first
    always_comb begin
        if (irq) begin
            act = ACT_IRQ;
        end else if (ex_taken) begin
            act = ACT_SQUASH;
        end else if (of_req && gnt == GNT_WBACK) begin
            act = ACT_OF_WAIT;
        end else if (gnt != GNT_FETCH) begin
            act = ACT_FI_WAIT;
        end else begin
            act = ACT_FLOW;
        end
    end

    // stage controls per decision
    always_comb begin
        kill       = '0;
        hold       = '0;
        fetch_take = 1'b0;
        unique case (act)
            ACT_FLOW: begin
                fetch_take = 1'b1;
            end
            ACT_FI_WAIT: begin
                fetch_take = 1'b0;
            end
            ACT_OF_WAIT: begin
                for (int k = 1; k < NSTG; k++) begin
                    if (k <= OF_STG) hold[k] = 1'b1;
                end
                kill[OF_STG+1] = 1'b1;
            end
            ACT_SQUASH: begin
                for (int k = 1; k < NSTG; k++) begin
                    if (k <= EX_STG) kill[k] = 1'b1;
                end
            end
            ACT_IRQ: begin
                kill = '1;
            end
            default: begin
                kill = '1;
            end
        endcase
    end

endmodule

// File: rtl/pipe6_stage.sv
module pipe6_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         kill,
    input  logic         hold,
    input  logic         din_vld,
    input  logic [W-1:0] din,
    output logic         q_vld,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld <= 1'b0;
            q     <= '0;
        end else if (kill) begin
            q_vld <= 1'b0;
        end else if (!hold) begin
            q_vld <= din_vld;
            q     <= din;
        end
    end

endmodule

// File: rtl/pipe6_seq.sv
module pipe6_seq
    import pipe6_pkg::*;
#(
    parameter int               IDX_W       = 8,
    parameter logic [IDX_W-1:0] RESET_IDX   = '0,
    parameter logic [IDX_W-1:0] HANDLER_IDX = 8'hF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq,
    input  logic             in_br,
    input  logic             in_taken,
    input  logic [IDX_W-1:0] in_tgt,
    input  logic             in_opnd_mem,
    input  logic             in_wb_mem,
    output logic [IDX_W-1:0] fetch_idx,
    output logic [1:0]       mem_grant,
    output logic             done_valid,
    output logic [IDX_W-1:0] done_tag
);

    // slot payload layout
    localparam int F_WBM     = 0;
    localparam int F_OPM     = 1;
    localparam int F_TKN     = 2;
    localparam int F_BR      = 3;
    localparam int F_TGT_LSB = 4;
    localparam int F_TAG_LSB = F_TGT_LSB + IDX_W;
    localparam int PW        = F_TAG_LSB + IDX_W;

    logic [IDX_W-1:0] pc;
    logic [PW-1:0]    fetch_pay;
    logic [PW-1:0]    pay [1:NSTG-1];
    logic [NSTG-1:1]  vld;
    logic [NSTG-1:1]  kill;
    logic [NSTG-1:1]  hold;
    logic             fetch_take;
    logic             wb_req;
    logic             of_req;
    logic             ex_taken;
    logic [IDX_W-1:0] ex_tgt;
    gnt_e             gnt;
    act_e             act;
    logic             unused_fields;

    assign fetch_pay = {pc, in_tgt, in_br, in_taken, in_opnd_mem, in_wb_mem};

    assign wb_req   = vld[WB_STG] & pay[WB_STG][F_WBM];
    assign of_req   = vld[OF_STG] & pay[OF_STG][F_OPM];
    assign ex_taken = vld[EX_STG] & pay[EX_STG][F_BR] & pay[EX_STG][F_TKN];
    assign ex_tgt   = pay[EX_STG][F_TGT_LSB +: IDX_W];

    pipe6_port_arb u_arb (
        .wb_req (wb_req),
        .of_req (of_req),
        .fi_req (1'b1),
        .gnt    (gnt)
    );

    pipe6_ctl u_ctl (
        .irq        (irq),
        .ex_taken   (ex_taken),
        .of_req     (of_req),
        .gnt        (gnt),
        .act        (act),
        .kill       (kill),
        .hold       (hold),
        .fetch_take (fetch_take)
    );

    for (genvar k = 1; k < NSTG; k++) begin : g_stg
        logic [PW-1:0] d;
        logic          dv;
        if (k == 1) begin : g_head
            assign d  = fetch_pay;
            assign dv = fetch_take;
        end else begin : g_body
            assign d  = pay[k-1];
            assign dv = vld[k-1];
        end
        pipe6_stage #(.W(PW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .kill    (kill[k]),
            .hold    (hold[k]),
            .din_vld (dv),
            .din     (d),
            .q_vld   (vld[k]),
            .q       (pay[k])
        );
    end

    // fetch index register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_IDX;
        end else begin
            unique case (act)
                ACT_IRQ:     pc <= HANDLER_IDX;
                ACT_SQUASH:  pc <= ex_tgt;
                ACT_FLOW:    pc <= pc + 1'b1;
                ACT_FI_WAIT: pc <= pc;
                ACT_OF_WAIT: pc <= pc;
                default:     pc <= pc;
            endcase
        end
    end

    assign fetch_idx  = pc;
    assign mem_grant  = gnt;
    assign done_valid = vld[WB_STG];
    assign done_tag   = pay[WB_STG][F_TAG_LSB +: IDX_W];

    assign unused_fields = ^{pay[WB_STG][F_TGT_LSB +: IDX_W], pay[WB_STG][F_BR],
                             pay[WB_STG][F_TKN], pay[WB_STG][F_OPM]};

    // R3: write back is served first, operand fetch second
    a_r3_wb_first: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> mem_grant == 2'd3);
    a_r3_of_second: assert property (@(posedge clk) disable iff (!rst_n)
        (of_req && !wb_req) |-> mem_grant == 2'd2);
    // R4: operand-fetch stall freezes fetch and bubbles execute
    a_r4_fetch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (of_req && wb_req && !irq && !ex_taken) |=> $stable(fetch_idx));
    a_r4_ex_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (of_req && wb_req && !irq && !ex_taken) |=> !vld[EX_STG]);
    // R2: write back is always fed from execute
    a_r2_wb_from_ex: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(vld[EX_STG]));
    // R8, R9: taken branch redirects fetch to its target
    a_r8_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_taken && !irq) |=> fetch_idx == $past(ex_tgt));
    // R10, R11: interrupt restarts at the handler with the pipe emptied
    a_r10_handler: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (fetch_idx == HANDLER_IDX) && !done_valid && (vld == '0));

endmodule

// File: tb/tb_pipe6_seq.sv
module tb_pipe6_seq;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 8;
    localparam int HANDLER    = 8'hF0;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             irq = 1'b0;
    logic             in_br, in_taken, in_opnd_mem, in_wb_mem;
    logic [IDX_W-1:0] in_tgt;
    logic [IDX_W-1:0] fetch_idx;
    logic [1:0]       mem_grant;
    logic             done_valid;
    logic [IDX_W-1:0] done_tag;

    logic [255:0]     p_br, p_tkn, p_opm, p_wbm;
    logic [IDX_W-1:0] p_tgt [256];

    int    exp_q[$];
    int    done_at [256];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    mon_en = 1'b0;
    string sb_req = "R2";

    always #(CLK_PERIOD/2) clk = ~clk;

    assign in_br       = p_br[fetch_idx];
    assign in_taken    = p_tkn[fetch_idx];
    assign in_opnd_mem = p_opm[fetch_idx];
    assign in_wb_mem   = p_wbm[fetch_idx];
    assign in_tgt      = p_tgt[fetch_idx];

    pipe6_seq #(.IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .irq(irq),
        .in_br(in_br), .in_taken(in_taken), .in_tgt(in_tgt),
        .in_opnd_mem(in_opnd_mem), .in_wb_mem(in_wb_mem),
        .fetch_idx(fetch_idx), .mem_grant(mem_grant),
        .done_valid(done_valid), .done_tag(done_tag)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_en && rst_n && done_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, {sb_req, " unexpected completion"}, int'(done_tag), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(done_tag) == e, {sb_req, " completion order"}, int'(done_tag), e);
                done_at[done_tag] = cyc;
            end
        end
    end

    task automatic begin_test(input string req);
        @(negedge clk);
        rst_n  = 1'b0;
        irq    = 1'b0;
        mon_en = 1'b0;
        sb_req = req;
        exp_q.delete();
        p_br = '0; p_tkn = '0; p_opm = '0; p_wbm = '0;
        for (int i = 0; i < 256; i++) begin
            p_tgt[i]   = '0;
            done_at[i] = -1;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic push_range(input int first, input int last);
        for (int i = first; i <= last; i++) exp_q.push_back(i);
    endtask

    task automatic release_rst();
        rst_n  = 1'b1;
        mon_en = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        while (exp_q.size() > 0 && t < 100) begin
            @(negedge clk);
            t++;
        end
        chk(exp_q.size() == 0, {req, " all expected completions seen"}, exp_q.size(), 0);
        mon_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // T1: sequential stream, R1 R2 R6
        begin_test("R2");
        chk(fetch_idx == 0, "R1 fetch index in reset", fetch_idx, 0);
        chk(done_valid == 1'b0, "R1 no completion in reset", done_valid, 0);
        push_range(0, 9);
        release_rst();
        chk(fetch_idx == 0, "R1 fetch index after reset", fetch_idx, 0);
        for (int c = 0; c <= 12; c++) begin
            wait_cyc(c);
            chk(mem_grant == 2'd1, "R6 grant stays fetch", mem_grant, 1);
            if (c < 5) chk(done_valid == 1'b0, "R1 no early completion", done_valid, 0);
        end
        drain("R2");
        chk(done_at[0] == 5, "R2 latency of first", done_at[0], 5);
        chk(done_at[9] == 14, "R2 one per cycle", done_at[9], 14);

        // T2: memory conflicts, R3 R4 R5
        begin_test("R4");
        p_wbm[0] = 1'b1;
        p_opm[2] = 1'b1;
        push_range(0, 7);
        release_rst();
        wait_cyc(5);
        chk(mem_grant == 2'd3, "R3 write back wins", mem_grant, 3);
        chk(fetch_idx == 5, "R4 fetch index", fetch_idx, 5);
        wait_cyc(6);
        chk(mem_grant == 2'd2, "R3 operand fetch served", mem_grant, 2);
        chk(fetch_idx == 5, "R4 fetch frozen during stall", fetch_idx, 5);
        wait_cyc(7);
        chk(mem_grant == 2'd1, "R3 fetch served", mem_grant, 1);
        chk(fetch_idx == 5, "R5 fetch index held after loss", fetch_idx, 5);
        wait_cyc(8);
        chk(fetch_idx == 6, "R5 fetch resumes", fetch_idx, 6);
        drain("R4");
        chk(done_at[1] == 6, "R4 older instruction unaffected", done_at[1], 6);
        chk(done_at[2] == 8, "R4 stalled instruction delayed", done_at[2], 8);
        chk(done_at[4] == 10, "R4 younger follow", done_at[4], 10);
        chk(done_at[5] == 12, "R5 decode bubble", done_at[5], 12);

        // T3: not-taken branch, R7
        begin_test("R7");
        p_br[4] = 1'b1; p_tgt[4] = 8'd12;
        push_range(0, 9);
        release_rst();
        wait_cyc(9);
        chk(fetch_idx == 9, "R7 sequential fetch kept", fetch_idx, 9);
        drain("R7");
        chk(done_at[5] == 10, "R7 no gap after branch", done_at[5], 10);

        // T4: taken branch, R8
        begin_test("R8");
        p_br[4] = 1'b1; p_tkn[4] = 1'b1; p_tgt[4] = 8'd12;
        push_range(0, 4);
        push_range(12, 14);
        release_rst();
        wait_cyc(9);
        chk(fetch_idx == 12, "R8 redirect to target", fetch_idx, 12);
        drain("R8");
        chk(done_at[4] == 9, "R8 branch completes", done_at[4], 9);
        chk(done_at[12] == 14, "R8 four empty cycles", done_at[12], 14);

        // T5: squash beats stall, R9
        begin_test("R9");
        p_br[4] = 1'b1; p_tkn[4] = 1'b1; p_tgt[4] = 8'd12;
        p_opm[5] = 1'b1; p_wbm[3] = 1'b1;
        push_range(0, 4);
        push_range(12, 14);
        release_rst();
        wait_cyc(8);
        chk(mem_grant == 2'd3, "R3 write back in squash cycle", mem_grant, 3);
        wait_cyc(9);
        chk(fetch_idx == 12, "R9 redirect despite stall", fetch_idx, 12);
        drain("R9");
        chk(done_at[12] == 14, "R9 target timing", done_at[12], 14);

        // T6: interrupt, R10
        begin_test("R10");
        exp_q.push_back(0);
        exp_q.push_back(1);
        push_range(HANDLER, HANDLER + 2);
        release_rst();
        wait_cyc(6);
        irq = 1'b1;
        wait_cyc(7);
        irq = 1'b0;
        chk(fetch_idx == HANDLER, "R10 handler fetch", fetch_idx, HANDLER);
        chk(done_valid == 1'b0, "R10 pipe emptied", done_valid, 0);
        drain("R10");
        chk(done_at[1] == 6, "R10 write back completes", done_at[1], 6);
        chk(done_at[HANDLER] == 12, "R10 handler completion", done_at[HANDLER], 12);

        // T7: interrupt beats branch, R11
        begin_test("R11");
        p_br[4] = 1'b1; p_tkn[4] = 1'b1; p_tgt[4] = 8'd12;
        push_range(0, 3);
        push_range(HANDLER, HANDLER + 1);
        release_rst();
        wait_cyc(8);
        irq = 1'b1;
        wait_cyc(9);
        irq = 1'b0;
        chk(fetch_idx == HANDLER, "R11 handler over target", fetch_idx, HANDLER);
        drain("R11");
        chk(done_at[4] == -1, "R11 branch dropped", done_at[4], -1);
        chk(done_at[HANDLER] == 14, "R11 handler completion", done_at[HANDLER], 14);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule